// File: doc/BRIEF.md
# Byte-Serial Data-Move Instruction Decoder

This block takes an instruction stream one byte at a time and decodes the family of data-move instructions. Each accepted byte advances a small state machine. The machine handles, in this order: an optional operand-size prefix, the opcode, an optional register/memory selector byte (ModRM-style), and any trailing immediate or memory-offset bytes. When the last byte of an instruction arrives, the block emits one decoded record. The record gives the direction, operand size, source kind, destination index, destination-is-segment flag and the assembled immediate or offset value.

Two static inputs come from the surrounding pipeline: the default operand size and the address size. The decoder does not compute addresses or execute anything. It flags an invalid opcode for three cases: opcodes outside the family, a code-segment load, and the immediate group with a nonzero reg field. In each case it then treats the next byte as the start of a new instruction.

Top module: `mov_byte_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` and `out_fault` are 0. After reset, and after a reset that interrupts an instruction, the next accepted byte is decoded as an opcode or prefix.
- R2: Opcodes 88h-8Bh read a selector byte with mod in bits 7:6, reg in bits 5:3 and rm in bits 2:0. Opcode bit 0 chooses byte (0) or full size (1). Opcode bit 1 set gives `out_dir`=1 and `out_reg`=reg; clear gives `out_dir`=0 and `out_reg`=rm. The source kind is general register and `out_imm`=0.
- R3: Opcode 8Ch gives source kind segment, `out_dir`=0 and `out_reg`=rm. Opcode 8Eh gives source kind general register, `out_seg`=1, `out_dir`=1 and `out_reg`=reg. Both report word size.
- R4: Opcode 8Eh with reg field 1 (code segment) raises `out_fault` and produces no record.
- R5: Opcodes A0h-A3h take an offset of 4 bytes when `addr_size32`=1 and 2 bytes otherwise. A0h/A1h give `out_dir`=1 and A2h/A3h give `out_dir`=0. The even opcode is byte size. `out_reg`=0 and the source kind is memory offset.
- R6: Opcodes B0h-BFh load an immediate into register index opcode[2:0], with `out_dir`=1. Opcode bit 3 clear means a 1-byte immediate and byte size. Opcode bit 3 set means full size, with a 2-byte or 4-byte immediate.
- R7: C6h/C7h with reg field 0 take an immediate of the operand size into rm, with `out_dir`=0. A nonzero reg field raises `out_fault` right after the selector byte, and no immediate bytes are consumed.
- R8: Full size is dword when `op_size32` XOR prefix is 1, and word otherwise. Prefix 66h sets that prefix flag for the next instruction only. Byte forms stay byte size with or without it.
- R9: Any opcode byte outside the family raises `out_fault` for exactly one cycle, starting the cycle after that byte. The next byte is decoded as an opcode.
- R10: Immediates and offsets are assembled least significant byte first and zero-extended to 32 bits.
- R11: Bytes presented with `in_valid`=0 are ignored and leave decoding unchanged. No record or fault appears in the cycle after such a byte.
- R12: `out_valid` is a one-cycle pulse, in the cycle after the final byte. `out_size` is encoded 0=byte, 1=word, 2=dword. `out_src` is encoded 0=general register, 1=immediate, 2=segment register, 3=memory offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Instruction stream byte |
| op_size32 | input | 1 | Default full operand size is 32 bits |
| addr_size32 | input | 1 | Address size is 32 bits (offset width) |
| out_valid | output | 1 | Decoded record pulse |
| out_fault | output | 1 | Invalid-opcode pulse |
| out_dir | output | 1 | 1 when the named register is the destination |
| out_size | output | 2 | Operand size code |
| out_src | output | 2 | Source kind code |
| out_seg | output | 1 | Destination is a segment register |
| out_reg | output | 3 | Destination index |
| out_imm | output | 32 | Immediate or offset value |

## Verification
On every cycle, the assertions check the following. A record and a fault never appear together, and a record never lasts two cycles. Idle input never produces output in the next cycle. Segment-related records always report word size, and no record ever loads segment index 1. Offset records always name the accumulator, and byte immediates carry no bits above bit 7. The bench's scenarios are needed for the rest: the decoded field values of each opcode form, the byte order of multi-byte values, the sticky-for-one-instruction behaviour of the prefix, offset width under both address sizes, the number of bytes consumed before a fault, and resynchronisation after a fault or a mid-instruction reset.

// File: rtl/movdec_pkg.sv
package movdec_pkg;

    localparam int unsigned IMM_W     = 32;
    localparam int unsigned IMM_BYTES = IMM_W / 8;
    localparam int unsigned CNT_W     = $clog2(IMM_BYTES) + 1;
    localparam logic [7:0]  PFX_OPSIZE = 8'h66;
    localparam logic [2:0]  CODE_SEG   = 3'd1;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} opsize_e;
    typedef enum logic [1:0] {SRC_GPR = 2'd0, SRC_IMM = 2'd1, SRC_SREG = 2'd2, SRC_MOFFS = 2'd3} srckind_e;
    typedef enum logic [1:0] {ST_OPC = 2'd0, ST_MODRM = 2'd1, ST_TAIL = 2'd2} dstate_e;

    // Per-instruction attributes kept from the opcode byte until the record goes out.
    typedef struct packed {
        logic             dir;
        logic             seg_dst;
        logic             grp0;
        opsize_e          size;
        srckind_e         src;
        logic [CNT_W-1:0] len;
    } opinfo_t;

    function automatic logic [CNT_W-1:0] size_bytes(opsize_e s);
        case (s)
            SZ_BYTE: return CNT_W'(1);
            SZ_WORD: return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/movdec_classify.sv
module movdec_classify
    import movdec_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       wide,
    input  logic       a32,
    output logic       known,
    output logic       has_modrm,
    output logic       reg_in_opc,
    output opinfo_t    info
);
    opsize_e full_sz;
    opsize_e bit0_sz;

    always_comb begin
        full_sz    = wide ? SZ_DWORD : SZ_WORD;
        bit0_sz    = opc[0] ? full_sz : SZ_BYTE;
        known      = 1'b0;
        has_modrm  = 1'b0;
        reg_in_opc = 1'b0;
        info       = '0;
        casez (opc)
            8'b1000_10??: begin
                known = 1'b1; has_modrm = 1'b1;
                info.dir = opc[1]; info.size = bit0_sz; info.src = SRC_GPR;
            end
            8'h8C: begin
                known = 1'b1; has_modrm = 1'b1;
                info.size = SZ_WORD; info.src = SRC_SREG;
            end
            8'h8E: begin
                known = 1'b1; has_modrm = 1'b1;
                info.dir = 1'b1; info.seg_dst = 1'b1;
                info.size = SZ_WORD; info.src = SRC_GPR;
            end
            8'b1010_00??: begin
                known = 1'b1;
                info.dir = ~opc[1]; info.size = bit0_sz; info.src = SRC_MOFFS;
                info.len = a32 ? CNT_W'(4) : CNT_W'(2);
            end
            8'b1011_????: begin
                known = 1'b1; reg_in_opc = 1'b1;
                info.dir  = 1'b1;
                info.size = opc[3] ? full_sz : SZ_BYTE;
                info.src  = SRC_IMM;
                info.len  = size_bytes(opc[3] ? full_sz : SZ_BYTE);
            end
            8'b1100_011?: begin
                known = 1'b1; has_modrm = 1'b1;
                info.grp0 = 1'b1; info.size = bit0_sz; info.src = SRC_IMM;
                info.len  = size_bytes(bit0_sz);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/movdec_lecat.sv
module movdec_lecat
    import movdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [IMM_W-1:0] acc_nxt
);
    logic [IMM_W-1:0] acc;

    // One lane per byte position; the lane picked by idx takes the new byte.
    for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
        assign acc_nxt[8*g +: 8] = (load && idx == CNT_W'(g)) ? din : acc[8*g +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else            acc <= acc_nxt;
    end
endmodule

// File: rtl/mov_byte_decoder.sv
module mov_byte_decoder
    import movdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             op_size32,
    input  logic             addr_size32,
    output logic             out_valid,
    output logic             out_fault,
    output logic             out_dir,
    output logic [1:0]       out_size,
    output logic [1:0]       out_src,
    output logic             out_seg,
    output logic [2:0]       out_reg,
    output logic [IMM_W-1:0] out_imm
);
    dstate_e          state;
    logic             pfx;
    opinfo_t          info_q;
    logic [2:0]       dst_q;
    logic [CNT_W-1:0] cnt_q;

    logic             c_known, c_modrm, c_rin;
    opinfo_t          c_info;
    logic [IMM_W-1:0] acc_nxt;
    logic [2:0]       sel_reg, sel_rm, modrm_dst;
    logic             modrm_bad, tail_last;

    movdec_classify u_cls (
        .opc        (in_byte),
        .wide       (op_size32 ^ pfx),
        .a32        (addr_size32),
        .known      (c_known),
        .has_modrm  (c_modrm),
        .reg_in_opc (c_rin),
        .info       (c_info)
    );

    movdec_lecat u_cat (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_valid && state == ST_OPC),
        .load    (in_valid && state == ST_TAIL),
        .idx     (cnt_q),
        .din     (in_byte),
        .acc_nxt (acc_nxt)
    );

    assign sel_reg   = in_byte[5:3];
    assign sel_rm    = in_byte[2:0];
    assign modrm_dst = info_q.dir ? sel_reg : sel_rm;
    assign modrm_bad = (info_q.grp0 && sel_reg != 3'd0) ||
                       (info_q.seg_dst && sel_reg == CODE_SEG);
    assign tail_last = (cnt_q == info_q.len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OPC;
            pfx       <= 1'b0;
            info_q    <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_dir   <= 1'b0;
            out_size  <= '0;
            out_src   <= '0;
            out_seg   <= 1'b0;
            out_reg   <= '0;
            out_imm   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            if (in_valid) begin
                unique case (state)
                    ST_OPC: begin
                        if (in_byte == PFX_OPSIZE) begin
                            pfx <= 1'b1;
                        end else begin
                            pfx <= 1'b0;
                            if (!c_known) begin
                                out_fault <= 1'b1;
                            end else begin
                                info_q <= c_info;
                                dst_q  <= c_rin ? in_byte[2:0] : 3'd0;
                                cnt_q  <= '0;
                                state  <= c_modrm ? ST_MODRM : ST_TAIL;
                            end
                        end
                    end
                    ST_MODRM: begin
                        if (modrm_bad) begin
                            out_fault <= 1'b1;
                            state     <= ST_OPC;
                        end else if (info_q.len == '0) begin
                            out_valid <= 1'b1;
                            out_dir   <= info_q.dir;
                            out_size  <= info_q.size;
                            out_src   <= info_q.src;
                            out_seg   <= info_q.seg_dst;
                            out_reg   <= modrm_dst;
                            out_imm   <= '0;
                            state     <= ST_OPC;
                        end else begin
                            dst_q <= modrm_dst;
                            state <= ST_TAIL;
                        end
                    end
                    ST_TAIL: begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (tail_last) begin
                            out_valid <= 1'b1;
                            out_dir   <= info_q.dir;
                            out_size  <= info_q.size;
                            out_src   <= info_q.src;
                            out_seg   <= info_q.seg_dst;
                            out_reg   <= dst_q;
                            out_imm   <= acc_nxt;
                            state     <= ST_OPC;
                        end
                    end
                    default: state <= ST_OPC;
                endcase
            end
        end
    end

    // R12: a record never spans two cycles
    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R9: fault and record are exclusive
    a_r9_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_fault));
    // R4: code segment is never a load target
    a_r4_no_cs_load: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_seg) |-> out_reg != CODE_SEG);
    // R3: segment moves are word sized
    a_r3_seg_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_seg || out_src == SRC_SREG)) |-> out_size == SZ_WORD);
    // R5: offset forms always use the accumulator
    a_r5_moffs_acc: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == SRC_MOFFS) |-> out_reg == 3'd0);
    // R11: idle cycle produces nothing next
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_fault));
    // R10: byte immediates are zero-extended
    a_r10_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == SRC_IMM && out_size == SZ_BYTE) |-> out_imm[IMM_W-1:8] == '0);
endmodule

// File: tb/mov_byte_decoder_test.sv
`timescale 1ns/1ps
module mov_byte_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        op_size32 = 1'b1;
    logic        addr_size32 = 1'b1;
    logic        out_valid, out_fault, out_dir, out_seg;
    logic [1:0]  out_size, out_src;
    logic [2:0]  out_reg;
    logic [31:0] out_imm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mov_byte_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .op_size32(op_size32), .addr_size32(addr_size32),
        .out_valid(out_valid), .out_fault(out_fault), .out_dir(out_dir),
        .out_size(out_size), .out_src(out_src), .out_seg(out_seg),
        .out_reg(out_reg), .out_imm(out_imm)
    );

    typedef struct packed {
        logic [63:0] bytes;  // byte i at [8*i +: 8]
        logic [3:0]  n;
        logic        a32;
        logic        w32;
        logic        flt;
        logic        dir;
        logic [1:0]  size;
        logic [1:0]  src;
        logic        seg;
        logic [2:0]  dst;
        logic [31:0] imm;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TAB [NV] = '{
        '{64'hD889,           4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 3'd0, 32'h0},        // R2 store dword
        '{64'h4B8A,           4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 3'd1, 32'h0},        // R2 load byte
        '{64'hC18B66,         4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 3'd0, 32'h0},        // R8 prefix to word
        '{64'hD88C,           4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 1'b0, 3'd0, 32'h0},        // R3 sreg store
        '{64'hD08E,           4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 3'd2, 32'h0},        // R3 sreg load
        '{64'hC88E,           4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0},        // R4 code segment
        '{64'h12345678A1,     4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd3, 1'b0, 3'd0, 32'h12345678}, // R5 R10 offset 32
        '{64'h1234A2,         4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 3'd0, 32'h1234},     // R5 offset 16
        '{64'hABB3,           4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 3'd3, 32'hAB},       // R6 byte imm
        '{64'h44332211BE,     4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 1'b0, 3'd6, 32'h44332211}, // R6 R10 dword imm
        '{64'hBEEFBA66,       4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 3'd2, 32'hBEEF},     // R8 word imm
        '{64'h7F05C6,         4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 3'd5, 32'h7F},       // R7 group imm
        '{64'hC8C7,           4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0},        // R7 reg field 1
        '{64'h0F,             4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0},        // R9 unknown
        '{64'h1234B8,         4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 3'd0, 32'h1234},     // R8 default word
        '{64'hC08866,         4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0},        // R8 byte unaffected
        '{64'h12345678C3C766, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 3'd3, 32'h12345678}  // R8 R10 dword group
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hFF;
    endtask

    task automatic expect_rec(input string tag, input logic dir, input logic [1:0] size,
                              input logic [1:0] src, input logic seg, input logic [2:0] dst,
                              input logic [31:0] imm);
        logic [63:0] a, e;
        a = {23'd0, out_valid, out_fault, out_dir, out_size, out_src, out_seg, out_reg, out_imm};
        e = {23'd0, 1'b1, 1'b0, dir, size, src, seg, dst, imm};
        chk(a == e, tag, a, e);
    endtask

    task automatic expect_fault(input string tag);
        chk(out_fault && !out_valid, tag, {62'd0, out_valid, out_fault}, 64'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!out_valid && !out_fault, "R1 in reset", {62'd0, out_valid, out_fault}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_fault, "R1 after reset", {62'd0, out_valid, out_fault}, 64'h0);

        // Table walk: each entry decoded back to back
        for (int i = 0; i < NV; i++) begin
            op_size32   = TAB[i].w32;
            addr_size32 = TAB[i].a32;
            for (int k = 0; k < int'(TAB[i].n); k++) put(TAB[i].bytes[8*k +: 8]);
            idle();
            if (TAB[i].flt)
                expect_fault($sformatf("vector %0d fault", i));
            else
                expect_rec($sformatf("vector %0d record", i), TAB[i].dir, TAB[i].size,
                           TAB[i].src, TAB[i].seg, TAB[i].dst, TAB[i].imm);
            idle();
            // R12 and R9: pulses last a single cycle
            chk(!out_valid && !out_fault, $sformatf("R12 R9 pulse end vector %0d", i),
                {62'd0, out_valid, out_fault}, 64'h0);
        end

        // R11: gaps inside an instruction are ignored
        op_size32 = 1'b1;
        put(8'hB1);
        for (int j = 0; j < 3; j++) begin
            idle();
            chk(!out_valid && !out_fault, "R11 gap quiet", {62'd0, out_valid, out_fault}, 64'h0);
        end
        put(8'h5A);
        idle();
        expect_rec("R11 record after gap", 1'b1, 2'd0, 2'd1, 1'b0, 3'd1, 32'h5A);

        // R8: prefix applies to one instruction only
        put(8'h66); put(8'h89); put(8'hC0);
        idle();
        expect_rec("R8 prefixed word", 1'b0, 2'd1, 2'd0, 1'b0, 3'd0, 32'h0);
        put(8'h89); put(8'hC0);
        idle();
        expect_rec("R8 prefix consumed", 1'b0, 2'd2, 2'd0, 1'b0, 3'd0, 32'h0);

        // R1: reset in mid-instruction returns to opcode decode
        put(8'hB0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        put(8'h89); put(8'hD8);
        idle();
        expect_rec("R1 resync after reset", 1'b0, 2'd2, 2'd0, 1'b0, 3'd0, 32'h0);

        // R9: fault then immediate resync on the following byte
        put(8'hF4); put(8'hB7); put(8'h99);
        idle();
        expect_rec("R9 resync after fault", 1'b1, 2'd0, 2'd1, 1'b0, 3'd7, 32'h99);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule